// File: doc/BRIEF.md
# I2C Bus Status and Arbitration Monitor

This block watches the SCL and SDA lines of an I2C bus together with the intent signals of a local bus controller, and keeps an 8-bit status byte that software reads to follow a transfer. The block finds START and STOP conditions and counts clock pulses into bytes. It compares the calling address with a programmed own address and notes the acknowledge bit. It also finds every way the local controller can lose arbitration: a bit read back low while it drives high, a start attempt on a busy bus, a repeated start while in slave mode, and a STOP that it did not ask for.

The lines are resynchronised to the system clock, and every edge is found by comparing the current sample with the previous one. Losing arbitration while being addressed as a slave needs special handling. In that case the interrupt flag is raised twice around the acknowledge bit: first on the rising SCL edge, then again on the falling edge. A late-acknowledge marker bit is set only for the second interrupt, so software can act at the second one. Three flags are sticky: arbitration lost, the marker and the interrupt flag. Software clears each of them by writing a zero to its bit.

Top module: `i2c_stat_mon`

## Requirements
- R1: After reset the status byte and the interrupt output are 0. Status bit positions are: bit 7 transfer complete, bit 6 addressed-as-slave, bit 5 bus busy, bit 4 arbitration lost, bit 3 late-acknowledge marker, bit 2 slave read/write, bit 1 interrupt flag, bit 0 received acknowledge.
- R2: Bus busy sets when SDA falls while SCL is high (START), and clears when SDA rises while SCL is high (STOP).
- R3: Transfer complete clears on the first rising SCL edge of a byte. It sets on the falling SCL edge that ends the 9th clock, and the interrupt flag sets with it.
- R4: Addressed-as-slave sets when the first 7 bits after a START equal the own address. Slave read/write then takes the 8th bit. A control-register write strobe clears addressed-as-slave.
- R5: Received acknowledge takes the SDA level on the rising SCL edge of the 9th clock (1 = not acknowledged).
- R6: Arbitration lost sets on a rising SCL edge where the controller drives SDA high but the line reads low. This covers data bits and the acknowledge bit.
- R7: Arbitration lost sets on a start request while the bus is busy, and on a repeated-start request while slave mode is indicated.
- R8: After a start request on an idle bus, a STOP seen without a prior stop request sets arbitration lost. A requested STOP does not set it.
- R9: Arbitration lost, the late-acknowledge marker and the interrupt flag clear only when a status write carries 0 in their bit. Writing 1 leaves them unchanged, and status writes do not change the other bits.
- R10: When arbitration lost and addressed-as-slave are both set, the interrupt flag sets on the rising SCL edge of the 9th clock with the marker still 0. It sets again on the falling edge of that clock, and this time the marker sets to 1.
- R11: The interrupt output equals the interrupt flag ANDed with the interrupt enable.
- R12: A hardware event that sets a sticky flag wins over a software clear of that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| mst_sda | input | 1 | SDA level the local controller wants to drive |
| mst_drive | input | 1 | Local controller is driving SDA |
| req_start | input | 1 | Start request pulse |
| req_stop | input | 1 | Stop request pulse |
| req_rstart | input | 1 | Repeated-start request pulse |
| slave_mode | input | 1 | Local controller is in slave mode |
| own_addr | input | ADDR_W | Own slave address |
| ctrl_wr | input | 1 | Control-register write strobe |
| stat_wr | input | 1 | Status-register write strobe |
| stat_wdata | input | 8 | Status-register write data |
| irq_en | input | 1 | Interrupt enable |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
A software clear of a sticky flag and a hardware event that sets the same flag can arrive on the same clock edge. The bench provokes this on a busy bus: it raises the start request and a status write with zeros in the arbitration-lost, marker and interrupt bits for the same single cycle. The result is correct only if arbitration lost and the interrupt flag both read 1 afterwards. The ordinary clear path is checked separately, so that a design where the clear always wins, or the set is lost, shows up as a difference between the two cases.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

   localparam int unsigned STAT_W = 8;

   // status bit positions (MSB first)
   localparam int unsigned B_DONE  = 7;
   localparam int unsigned B_ADDR  = 6;
   localparam int unsigned B_BUSY  = 5;
   localparam int unsigned B_LOST  = 4;
   localparam int unsigned B_LATE  = 3;
   localparam int unsigned B_RD    = 2;
   localparam int unsigned B_INT   = 1;
   localparam int unsigned B_NACK  = 0;

   typedef struct packed {
      logic xfer_done;
      logic addressed;
      logic busy;
      logic arb_lost;
      logic late_ack;
      logic slv_read;
      logic intr;
      logic nack;
   } stat_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cmon_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2cmon_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_p;
   logic sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   // SDA transitions only count as conditions while SCL stays high
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cmon_framer.sv
module i2cmon_framer #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned BYTE_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              active,
   output logic              byte_begin,
   output logic              ack_rise,
   output logic              byte_done,
   output logic              addr_hit,
   output logic              addr_rw
);

   localparam int unsigned CNT_W = $clog2(BYTE_BITS + 2);
   localparam logic [CNT_W-1:0] IDX_FIRST = '0;
   localparam logic [CNT_W-1:0] IDX_RW    = CNT_W'(BYTE_BITS - 1);
   localparam logic [CNT_W-1:0] IDX_ACK   = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] IDX_END   = CNT_W'(BYTE_BITS + 1);

   if (ADDR_W != BYTE_BITS - 1) begin : g_bad_addr
      $error("i2cmon_framer: ADDR_W must be BYTE_BITS-1");
   end

   logic [CNT_W-1:0]  idx_q;
   logic              first_q;
   logic              act_q;
   logic [ADDR_W-1:0] shreg_q;
   logic              data_rise;

   assign active     = act_q;
   assign data_rise  = act_q & scl_rise & (idx_q < IDX_ACK);
   assign byte_begin = act_q & scl_rise & (idx_q == IDX_FIRST);
   assign ack_rise   = act_q & scl_rise & (idx_q == IDX_ACK);
   assign byte_done  = act_q & scl_fall & (idx_q == IDX_END);
   assign addr_hit   = data_rise & first_q & (idx_q == IDX_RW) & (shreg_q == own_addr);
   assign addr_rw    = sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         first_q <= 1'b0;
         act_q   <= 1'b0;
         shreg_q <= '0;
      end else if (start_det) begin
         idx_q   <= '0;
         first_q <= 1'b1;
         act_q   <= 1'b1;
      end else if (stop_det) begin
         idx_q   <= '0;
         first_q <= 1'b0;
         act_q   <= 1'b0;
      end else if (act_q) begin
         if (data_rise) begin
            shreg_q <= {shreg_q[ADDR_W-2:0], sda_s};
         end
         if (scl_rise && idx_q < IDX_END) begin
            idx_q <= idx_q + 1'b1;
         end else if (byte_done) begin
            idx_q   <= '0;
            first_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/i2cmon_arb.sv
module i2cmon_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic scl_rise,
   input  logic sda_s,
   input  logic stop_det,
   input  logic bus_busy,
   input  logic mst_sda,
   input  logic mst_drive,
   input  logic req_start,
   input  logic req_stop,
   input  logic req_rstart,
   input  logic slave_mode,
   output logic al_evt
);

   logic owner_q;
   logic stop_pend_q;
   logic bit_loss;
   logic busy_start;
   logic slave_rstart;
   logic stray_stop;

   // read-back mismatch on any sampled bit, acknowledge included
   assign bit_loss     = active & scl_rise & mst_drive & mst_sda & ~sda_s;
   assign busy_start   = req_start & bus_busy;
   assign slave_rstart = req_rstart & slave_mode;
   assign stray_stop   = stop_det & owner_q & ~stop_pend_q;
   assign al_evt       = bit_loss | busy_start | slave_rstart | stray_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q     <= 1'b0;
         stop_pend_q <= 1'b0;
      end else begin
         if (al_evt || stop_det) owner_q <= 1'b0;
         else if (req_start && !bus_busy) owner_q <= 1'b1;

         if (al_evt || stop_det) stop_pend_q <= 1'b0;
         else if (req_stop && owner_q) stop_pend_q <= 1'b1;
      end
   end

endmodule

// File: rtl/i2c_stat_mon.sv
module i2c_stat_mon
   import i2cmon_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned BYTE_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HW_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              mst_sda,
   input  logic              mst_drive,
   input  logic              req_start,
   input  logic              req_stop,
   input  logic              req_rstart,
   input  logic              slave_mode,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ctrl_wr,
   input  logic              stat_wr,
   input  logic [7:0]        stat_wdata,
   input  logic              irq_en,
   output logic [7:0]        status,
   output logic              irq
);

   localparam int unsigned N_STICKY = 3;

   if (STAT_W != 8) begin : g_bad_stat
      $error("i2c_stat_mon: status byte must be 8 bits");
   end

   logic [1:0] lines_s;
   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;
   logic       active;
   logic       byte_begin;
   logic       ack_rise;
   logic       byte_done;
   logic       addr_hit;
   logic       addr_rw;
   logic       al_evt;
   stat_t      st_q;

   logic [N_STICKY-1:0] sticky_q;
   logic [N_STICKY-1:0] sticky_set;
   logic [N_STICKY-1:0] sticky_clr;
   logic [N_STICKY-1:0] sticky_d;
   logic                lost_and_addr;
   logic                unused_wdata;

   i2cmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (lines_s)
   );
   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   i2cmon_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cmon_framer #(.ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_s      (sda_s),
      .own_addr   (own_addr),
      .active     (active),
      .byte_begin (byte_begin),
      .ack_rise   (ack_rise),
      .byte_done  (byte_done),
      .addr_hit   (addr_hit),
      .addr_rw    (addr_rw)
   );

   i2cmon_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .scl_rise   (scl_rise),
      .sda_s      (sda_s),
      .stop_det   (stop_det),
      .bus_busy   (st_q.busy),
      .mst_sda    (mst_sda),
      .mst_drive  (mst_drive),
      .req_start  (req_start),
      .req_stop   (req_stop),
      .req_rstart (req_rstart),
      .slave_mode (slave_mode),
      .al_evt     (al_evt)
   );

   // sticky flags, index 2 = arbitration lost, 1 = late marker, 0 = interrupt
   assign lost_and_addr = st_q.arb_lost & st_q.addressed;
   assign sticky_q      = {st_q.arb_lost, st_q.late_ack, st_q.intr};
   assign sticky_set    = {al_evt,
                           byte_done & lost_and_addr,
                           byte_done | al_evt | (ack_rise & lost_and_addr)};
   assign sticky_clr    = {stat_wr & ~stat_wdata[B_LOST],
                           stat_wr & ~stat_wdata[B_LATE],
                           stat_wr & ~stat_wdata[B_INT]};
   assign unused_wdata  = ^{stat_wdata[B_DONE], stat_wdata[B_ADDR], stat_wdata[B_BUSY],
                            stat_wdata[B_RD], stat_wdata[B_NACK]};

   if (HW_SET_WINS) begin : g_set_wins
      assign sticky_d = sticky_set | (sticky_q & ~sticky_clr);
   end else begin : g_clr_wins
      assign sticky_d = (sticky_set | sticky_q) & ~sticky_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         if (byte_done)       st_q.xfer_done <= 1'b1;
         else if (byte_begin) st_q.xfer_done <= 1'b0;

         if (addr_hit)     st_q.addressed <= 1'b1;
         else if (ctrl_wr) st_q.addressed <= 1'b0;

         if (start_det)     st_q.busy <= 1'b1;
         else if (stop_det) st_q.busy <= 1'b0;

         if (addr_hit) st_q.slv_read <= addr_rw;
         if (ack_rise) st_q.nack     <= sda_s;

         st_q.arb_lost <= sticky_d[2];
         st_q.late_ack <= sticky_d[1];
         st_q.intr     <= sticky_d[0];
      end
   end

   assign status = st_q;
   assign irq    = st_q.intr & irq_en;

endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk
   import i2cmon_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] status,
   input logic       irq,
   input logic       irq_en,
   input logic       ctrl_wr,
   input logic       stat_wr,
   input logic [7:0] stat_wdata,
   input logic       req_start,
   input logic       start_det,
   input logic       stop_det
);

   p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> status[B_BUSY]);

   p_idle_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !status[B_BUSY]);

   p_done_brings_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[B_DONE]) |-> status[B_INT]);

   p_addr_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_ADDR] && !ctrl_wr |=> status[B_ADDR]);

   p_busy_start_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_start && status[B_BUSY] |=> status[B_LOST]);

   p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_LOST] && !(stat_wr && !stat_wdata[B_LOST]) |=> status[B_LOST]);

   p_int_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_INT] && !(stat_wr && !stat_wdata[B_INT]) |=> status[B_INT]);

   p_late_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[B_LATE]) |-> $past(status[B_LOST]) && $past(status[B_ADDR]));

   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

endmodule

bind i2c_stat_mon i2cmon_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .status     (status),
   .irq        (irq),
   .irq_en     (irq_en),
   .ctrl_wr    (ctrl_wr),
   .stat_wr    (stat_wr),
   .stat_wdata (stat_wdata),
   .req_start  (req_start),
   .start_det  (start_det),
   .stop_det   (stop_det)
);

// File: tb/test_i2c_stat_mon.sv
module test_i2c_stat_mon;

   localparam int PH = 8;
   localparam int F_DONE = 7, F_ADDR = 6, F_BUSY = 5, F_LOST = 4;
   localparam int F_LATE = 3, F_RD = 2, F_INT = 1, F_NACK = 0;
   localparam logic [7:0] CLR_STICKY = 8'hE5;
   localparam logic [7:0] CLR_INT    = 8'hFD;
   localparam logic [6:0] OWN        = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1;
   logic       mst_sda = 1'b0, mst_drive = 1'b0;
   logic       req_start = 1'b0, req_stop = 1'b0, req_rstart = 1'b0;
   logic       slave_mode = 1'b0;
   logic [6:0] own_addr = OWN;
   logic       ctrl_wr = 1'b0, stat_wr = 1'b0;
   logic [7:0] stat_wdata = 8'h00;
   logic       irq_en = 1'b0;
   logic [7:0] status;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2ns clk = ~clk;

   i2c_stat_mon i_i2c_stat_mon (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
      .mst_sda(mst_sda), .mst_drive(mst_drive),
      .req_start(req_start), .req_stop(req_stop), .req_rstart(req_rstart),
      .slave_mode(slave_mode), .own_addr(own_addr), .ctrl_wr(ctrl_wr),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
      .status(status), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic line(input logic c, input logic d);
      @(negedge clk);
      scl = c;
      sda = d;
      idle(PH);
   endtask

   task automatic bus_start();
      line(1'b1, 1'b1); line(1'b1, 1'b0); line(1'b0, 1'b0);
   endtask

   task automatic bus_stop();
      line(1'b0, 1'b0); line(1'b1, 1'b0); line(1'b1, 1'b1);
   endtask

   task automatic bus_bit(input logic b);
      line(1'b0, b); line(1'b1, b); line(1'b0, b);
   endtask

   task automatic send_byte(input logic [7:0] v, input logic ack);
      for (int i = 7; i >= 0; i--) bus_bit(v[i]);
      bus_bit(ack);
   endtask

   task automatic swr(input logic [7:0] v);
      @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
      @(negedge clk); stat_wr = 1'b0;
      idle(2);
   endtask

   task automatic pulse_start();
      @(negedge clk); req_start = 1'b1;
      @(negedge clk); req_start = 1'b0;
      idle(2);
   endtask

   task automatic pulse_stop();
      @(negedge clk); req_stop = 1'b1;
      @(negedge clk); req_stop = 1'b0;
      idle(2);
   endtask

   task automatic pulse_ctrl();
      @(negedge clk); ctrl_wr = 1'b1;
      @(negedge clk); ctrl_wr = 1'b0;
      idle(2);
   endtask

   task automatic t_reset();
      chk("R1 status after reset", status, 8'h00);
      chk("R1 irq after reset", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_busy();
      bus_start();
      chk("R2 busy after START", {7'b0, status[F_BUSY]}, 8'h01);
      bus_stop();
      chk("R2 idle after STOP", {7'b0, status[F_BUSY]}, 8'h00);
   endtask

   task automatic t_byte();
      bus_start();
      send_byte(8'hAA, 1'b0);
      chk("R3 done after 9th fall", {7'b0, status[F_DONE]}, 8'h01);
      chk("R3 int with done", {7'b0, status[F_INT]}, 8'h01);
      chk("R5 ack received", {7'b0, status[F_NACK]}, 8'h00);
      chk("R4 no match", {7'b0, status[F_ADDR]}, 8'h00);
      swr(CLR_INT);
      line(1'b0, 1'b1); line(1'b1, 1'b1);
      chk("R3 done clears in byte", {7'b0, status[F_DONE]}, 8'h00);
      line(1'b0, 1'b1);
      for (int i = 0; i < 7; i++) bus_bit(1'b0);
      bus_bit(1'b1);
      chk("R5 nack received", {7'b0, status[F_NACK]}, 8'h01);
      chk("R3 done second byte", {7'b0, status[F_DONE]}, 8'h01);
      bus_stop();
      swr(CLR_STICKY);
   endtask

   task automatic t_addr();
      bus_start();
      send_byte({OWN, 1'b1}, 1'b0);
      chk("R4 addressed", {7'b0, status[F_ADDR]}, 8'h01);
      chk("R4 read bit", {7'b0, status[F_RD]}, 8'h01);
      bus_stop();
      swr(8'h00);
      chk("R9 write keeps addressed", {7'b0, status[F_ADDR]}, 8'h01);
      pulse_ctrl();
      chk("R4 ctrl write clears", {7'b0, status[F_ADDR]}, 8'h00);
   endtask

   task automatic t_sw();
      logic done_before;
      bus_start();
      pulse_start();
      chk("R7 start while busy", {7'b0, status[F_LOST]}, 8'h01);
      swr(8'hFF);
      chk("R9 write one keeps lost", {7'b0, status[F_LOST]}, 8'h01);
      chk("R9 write one keeps int", {7'b0, status[F_INT]}, 8'h01);
      done_before = status[F_DONE];
      swr(8'h00);
      chk("R9 write zero clears lost", {7'b0, status[F_LOST]}, 8'h00);
      chk("R9 write zero clears int", {7'b0, status[F_INT]}, 8'h00);
      chk("R9 busy untouched", {7'b0, status[F_BUSY]}, 8'h01);
      chk("R9 done untouched", {7'b0, status[F_DONE]}, {7'b0, done_before});
      bus_stop();
   endtask

   task automatic t_rstart();
      slave_mode = 1'b1;
      @(negedge clk); req_rstart = 1'b1;
      @(negedge clk); req_rstart = 1'b0;
      idle(2);
      chk("R7 repeated start in slave", {7'b0, status[F_LOST]}, 8'h01);
      slave_mode = 1'b0;
      swr(CLR_STICKY);
      @(negedge clk); req_rstart = 1'b1;
      @(negedge clk); req_rstart = 1'b0;
      idle(2);
      chk("R7 repeated start as master", {7'b0, status[F_LOST]}, 8'h00);
   endtask

   task automatic t_stop();
      pulse_start();
      chk("R8 start on idle bus", {7'b0, status[F_LOST]}, 8'h00);
      bus_start();
      bus_stop();
      chk("R8 unrequested stop", {7'b0, status[F_LOST]}, 8'h01);
      swr(CLR_STICKY);
      pulse_start();
      bus_start();
      pulse_stop();
      bus_stop();
      chk("R8 requested stop", {7'b0, status[F_LOST]}, 8'h00);
   endtask

   task automatic t_bitloss();
      bus_start();
      line(1'b0, 1'b0);
      @(negedge clk); mst_drive = 1'b1; mst_sda = 1'b1;
      line(1'b1, 1'b0);
      chk("R6 loss on data bit", {7'b0, status[F_LOST]}, 8'h01);
      line(1'b0, 1'b0);
      mst_drive = 1'b0;
      swr(CLR_STICKY);
      for (int i = 0; i < 7; i++) bus_bit(1'b0);
      chk("R6 no loss without drive", {7'b0, status[F_LOST]}, 8'h00);
      line(1'b0, 1'b0);
      @(negedge clk); mst_drive = 1'b1; mst_sda = 1'b1;
      line(1'b1, 1'b0);
      chk("R6 loss on ack bit", {7'b0, status[F_LOST]}, 8'h01);
      line(1'b0, 1'b0);
      mst_drive = 1'b0;
      bus_stop();
      swr(CLR_STICKY);
   endtask

   task automatic t_double();
      logic [7:0] a;
      a = {OWN, 1'b0};
      bus_start();
      line(1'b0, 1'b0);
      @(negedge clk); mst_drive = 1'b1; mst_sda = 1'b1;
      line(1'b1, 1'b0);
      line(1'b0, 1'b0);
      mst_drive = 1'b0;
      for (int i = 6; i >= 0; i--) bus_bit(a[i]);
      chk("R10 addressed after loss", {7'b0, status[F_ADDR]}, 8'h01);
      swr(CLR_INT);
      chk("R10 int cleared before ack", {7'b0, status[F_INT]}, 8'h00);
      line(1'b0, 1'b0); line(1'b1, 1'b0);
      chk("R10 first int on ack rise", {6'b0, status[F_INT], status[F_LATE]}, 8'h02);
      swr(CLR_INT);
      line(1'b0, 1'b0);
      chk("R10 second int on ack fall", {6'b0, status[F_INT], status[F_LATE]}, 8'h03);
      chk("R10 lost still set", {7'b0, status[F_LOST]}, 8'h01);
      swr(CLR_STICKY);
      chk("R9 marker cleared by zero", {7'b0, status[F_LATE]}, 8'h00);
      bus_stop();
      pulse_ctrl();
   endtask

   task automatic t_irq();
      slave_mode = 1'b1;
      @(negedge clk); req_rstart = 1'b1;
      @(negedge clk); req_rstart = 1'b0; slave_mode = 1'b0;
      idle(2);
      chk("R11 masked irq", {7'b0, irq}, 8'h00);
      irq_en = 1'b1;
      idle(1);
      chk("R11 enabled irq", {7'b0, irq}, 8'h01);
      swr(CLR_STICKY);
      chk("R11 irq follows flag", {7'b0, irq}, 8'h00);
      irq_en = 1'b0;
   endtask

   task automatic t_race();
      bus_start();
      @(negedge clk); req_start = 1'b1; stat_wr = 1'b1; stat_wdata = CLR_STICKY;
      @(negedge clk); req_start = 1'b0; stat_wr = 1'b0;
      idle(2);
      chk("R12 set beats clear lost", {7'b0, status[F_LOST]}, 8'h01);
      chk("R12 set beats clear int", {7'b0, status[F_INT]}, 8'h01);
      swr(CLR_STICKY);
      bus_stop();
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
      $finish;
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_busy();
      t_byte();
      t_addr();
      t_sw();
      t_rstart();
      t_stop();
      t_bitloss();
      t_double();
      t_irq();
      t_race();
      summary();
      $finish;
   end

endmodule